// File: doc/BRIEF.md
# Linked-List Descriptor Walker

This block drives one DMA channel through a chain of packed seven-word descriptors held in memory. Software sets the channel configuration word, the head pointer of the chain and the starting source and destination addresses, then raises the channel enable. The walker reads each descriptor one word at a time over a read-request/read-response stream. It then loads the block parameters into its channel outputs and starts one block on the downstream transfer engine. When that engine reports completion, the walker moves to the next descriptor.

Each descriptor carries the link to its successor, an element count, one address, a frame count, an interrupt mask and four index values. The address-handling codes decide, for source and destination independently, whether the next block takes the descriptor address, keeps the previous address, or continues past the previous block. The codes for the first block come from the configuration word. The codes for every later block come from the count word of the descriptor before it. A link value of 0xFFFFFFFC ends the chain. A link that is not word aligned stops the channel with an error.

Memory reads follow valid/ready rules. `rd_req_valid` stays high with `rd_req_addr` unchanged until `rd_req_ready` is seen, unless the channel enable drops first. The walker has only one request outstanding at a time. A response word is consumed in any cycle where both `rd_rsp_valid` and `rd_rsp_ready` are high.

Top module: `ll_desc_walker`

## Requirements
- R1: After reset, `busy`, `rd_req_valid`, `rd_rsp_ready`, `xfer_start`, `block_irq`, `chain_end` and `err_align` are 0, and `desc_num` is 0.
- R2: A walk starts only on a rising edge of `chan_en` while `cfg_mode[8]` is 1 (list mode) and `cfg_mode[5:4]` equals 2 (descriptor type 2). With `cfg_mode[8]`=0 or any other type value, no read is issued and `busy` stays 0. `cfg_mode[10]` (fast mode) has no effect on the walk.
- R3: A descriptor at pointer P is read as seven word requests at P, P+4, ..., P+24, in that order, with one request outstanding at a time. While the channel is enabled, a request that is not yet accepted keeps `rd_req_valid` high and `rd_req_addr` unchanged.
- R4: Word 0 holds the next pointer and word 2 holds the descriptor address. Word 1 holds the element count in [23:0]. Word 3 holds the frame count in [15:0] and the interrupt mask in [31:16]. Word 4 holds the destination element index in [15:0] and the source element index in [31:16]. Words 5 and 6 hold the destination and source frame indices. These values appear on the `cur_*` outputs while `xfer_start` is high.
- R5: For each block, the destination code and the source code each select the new address. Code 0 means the previous address plus previous element count × previous frame count × ELEM_BYTES (4 by default; the previous counts are 0 for the first block). Code 1 means the descriptor address. Codes 2 and 3 keep the previous address. The first block takes its destination code from `cfg_mode[1:0]` and its source code from `cfg_mode[3:2]`. Later blocks take their destination code from bits [27:26] and their source code from bits [25:24] of the previous descriptor's word 1.
- R6: After the last word of a descriptor is accepted, `xfer_start` is high for exactly one cycle. The walker then waits for `xfer_done` before reading anything else.
- R7: `block_irq` is high for one cycle, in the cycle after `xfer_done` is sampled, only if bit 5 of the loaded interrupt mask is 1. Otherwise it stays 0.
- R8: After a block completes, the walker follows the loaded next pointer. A pointer (head or next) equal to 0xFFFFFFFC issues no read, drops `busy`, and holds `chain_end` at 1 until `chan_en` falls.
- R9: `desc_num` is cleared to 0 when a walk starts and increases by one for each descriptor loaded.
- R10: A pointer (head or next) whose bits [1:0] are not 00 and that is not 0xFFFFFFFC issues no read and starts no block. It drops `busy` and holds `err_align` at 1 until `chan_en` falls.
- R11: If `chan_en` falls during a descriptor fetch, no further request is issued. The walker takes the response to a request already accepted, starts no block, and returns to idle with `busy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; a rising edge starts a walk |
| cfg_mode | input | 11 | Channel configuration word (address codes, type, list mode, fast mode) |
| cfg_head_ptr | input | 32 | Address of the first descriptor |
| cfg_src_addr | input | 32 | Source address before the first block |
| cfg_dst_addr | input | 32 | Destination address before the first block |
| rd_req_valid | output | 1 | Word read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 32 | Byte address of the requested word |
| rd_rsp_valid | input | 1 | Response word valid |
| rd_rsp_ready | output | 1 | Walker accepts the response word |
| rd_rsp_data | input | 32 | Response word |
| xfer_start | output | 1 | One-cycle start of a block transfer |
| xfer_done | input | 1 | Transfer engine finished the block |
| cur_src | output | 32 | Source address for the current block |
| cur_dst | output | 32 | Destination address for the current block |
| cur_elem | output | 24 | Element count |
| cur_frame | output | 16 | Frame count |
| cur_irq_mask | output | 16 | Interrupt mask of the loaded descriptor |
| cur_dst_ei | output | 16 | Destination element index |
| cur_src_ei | output | 16 | Source element index |
| cur_dst_fi | output | 32 | Destination frame index |
| cur_src_fi | output | 32 | Source frame index |
| desc_num | output | 16 | Descriptors loaded in this walk |
| block_irq | output | 1 | Block-complete interrupt pulse |
| chain_end | output | 1 | Chain finished at the end sentinel |
| err_align | output | 1 | Walk stopped on a misaligned pointer |
| busy | output | 1 | A walk is in progress |

## Verification
The hardest cases to reach are those where the address code of a block comes from a descriptor fetched one block earlier. Increment mode needs the previous block's lengths, so an error there shows up only in the second or third block of a chain. The bench therefore sweeps all nine first-block code pairs against all nine linked code pairs, over chains of one to three descriptors. Read-request stalls and response delays follow a cycle pattern of their own. Fetches are also aborted after each of the seven word requests, which lands the disable both inside and between outstanding reads.

// File: rtl/ll_walk_pkg.sv
package ll_walk_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned DESC_WORDS = 7;

  localparam logic [WORD_W-1:0] CHAIN_END_PTR = 32'hFFFF_FFFC;

  // address-handling codes
  localparam logic [1:0] AMODE_INC  = 2'd0;
  localparam logic [1:0] AMODE_LOAD = 2'd1;

  localparam logic [1:0] DESC_TYPE2 = 2'd2;

  // word slots inside a descriptor (fetch order is the packing order)
  localparam int unsigned SLOT_NEXT  = 0;
  localparam int unsigned SLOT_COUNT = 1;
  localparam int unsigned SLOT_ADDR  = 2;
  localparam int unsigned SLOT_FRAME = 3;
  localparam int unsigned SLOT_EIDX  = 4;
  localparam int unsigned SLOT_DFIDX = 5;
  localparam int unsigned SLOT_SFIDX = 6;

  typedef enum logic [3:0] {
    W_IDLE, W_CHECK, W_REQ, W_RSP, W_LOAD, W_START, W_WAIT, W_END, W_ERR
  } walk_state_e;
endpackage

// File: rtl/ll_addr_step.sv
module ll_addr_step #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ELEM_W     = 24,
  parameter int unsigned FRAME_W    = 16,
  parameter int unsigned ELEM_BYTES = 4
) (
  input  logic [1:0]         amode,
  input  logic [ADDR_W-1:0]  prev_addr,
  input  logic [ADDR_W-1:0]  desc_addr,
  input  logic [ELEM_W-1:0]  prev_elem,
  input  logic [FRAME_W-1:0] prev_frame,
  output logic [ADDR_W-1:0]  next_addr
);
  import ll_walk_pkg::*;

  logic [ADDR_W-1:0] step;

  always_comb begin
    step = ADDR_W'(prev_elem) * ADDR_W'(prev_frame) * ADDR_W'(ELEM_BYTES);
    case (amode)
      AMODE_INC:  next_addr = prev_addr + step;
      AMODE_LOAD: next_addr = desc_addr;
      default:    next_addr = prev_addr;
    endcase
  end
endmodule

// File: rtl/ll_desc_buf.sv
module ll_desc_buf #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NWORDS = 7,
  localparam int unsigned IDX_W = $clog2(NWORDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [WORD_W-1:0]        wr_data,
  output logic [NWORDS*WORD_W-1:0] words_flat
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))
        word_q <= wr_data;
    end
    assign words_flat[g*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/ll_desc_walker.sv
module ll_desc_walker #(
  parameter int unsigned ELEM_BYTES   = 4,
  parameter int unsigned BLOCK_IE_BIT = 5,
  parameter int unsigned CNT_W        = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chan_en,
  input  logic [10:0] cfg_mode,
  input  logic [31:0] cfg_head_ptr,
  input  logic [31:0] cfg_src_addr,
  input  logic [31:0] cfg_dst_addr,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [31:0] rd_req_addr,
  input  logic        rd_rsp_valid,
  output logic        rd_rsp_ready,
  input  logic [31:0] rd_rsp_data,
  output logic        xfer_start,
  input  logic        xfer_done,
  output logic [31:0] cur_src,
  output logic [31:0] cur_dst,
  output logic [23:0] cur_elem,
  output logic [15:0] cur_frame,
  output logic [15:0] cur_irq_mask,
  output logic [15:0] cur_dst_ei,
  output logic [15:0] cur_src_ei,
  output logic [31:0] cur_dst_fi,
  output logic [31:0] cur_src_fi,
  output logic [15:0] desc_num,
  output logic        block_irq,
  output logic        chain_end,
  output logic        err_align,
  output logic        busy
);
  import ll_walk_pkg::*;

  localparam int unsigned W       = WORD_W;
  localparam int unsigned NW      = DESC_WORDS;
  localparam int unsigned IDX_W   = $clog2(NW);
  localparam int unsigned ELEM_W  = 24;
  localparam int unsigned FRAME_W = 16;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NW - 1);

  walk_state_e       state;
  logic              en_q;
  logic [W-1:0]      ptr;
  logic [IDX_W-1:0]  widx;
  logic [1:0]        pend_dm, pend_sm;
  logic [CNT_W-1:0]  cnt_q;
  logic [NW*W-1:0]   desc_words;
  logic [W-1:0]      w_next, w_count, w_addr, w_frame, w_eidx;
  logic [W-1:0]      nxt_src, nxt_dst;
  logic              start_ok;
  logic              walk_unused;

  ll_desc_buf #(.WORD_W(W), .NWORDS(NW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(state == W_RSP && rd_rsp_valid),
    .wr_idx(widx), .wr_data(rd_rsp_data),
    .words_flat(desc_words)
  );

  assign w_next  = desc_words[SLOT_NEXT*W  +: W];
  assign w_count = desc_words[SLOT_COUNT*W +: W];
  assign w_addr  = desc_words[SLOT_ADDR*W  +: W];
  assign w_frame = desc_words[SLOT_FRAME*W +: W];
  assign w_eidx  = desc_words[SLOT_EIDX*W  +: W];
  assign walk_unused = ^{w_count[31:28], cfg_mode[10:9], cfg_mode[7:6]};

  ll_addr_step #(.ADDR_W(W), .ELEM_W(ELEM_W), .FRAME_W(FRAME_W), .ELEM_BYTES(ELEM_BYTES)) u_dst_step (
    .amode(pend_dm), .prev_addr(cur_dst), .desc_addr(w_addr),
    .prev_elem(cur_elem), .prev_frame(cur_frame), .next_addr(nxt_dst)
  );
  ll_addr_step #(.ADDR_W(W), .ELEM_W(ELEM_W), .FRAME_W(FRAME_W), .ELEM_BYTES(ELEM_BYTES)) u_src_step (
    .amode(pend_sm), .prev_addr(cur_src), .desc_addr(w_addr),
    .prev_elem(cur_elem), .prev_frame(cur_frame), .next_addr(nxt_src)
  );

  assign start_ok = chan_en && !en_q && cfg_mode[8] && cfg_mode[5:4] == DESC_TYPE2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= W_IDLE;
      en_q <= 1'b0;
      ptr <= '0;
      widx <= '0;
      pend_dm <= '0;
      pend_sm <= '0;
      cnt_q <= '0;
      block_irq <= 1'b0;
      cur_src <= '0;
      cur_dst <= '0;
      cur_elem <= '0;
      cur_frame <= '0;
      cur_irq_mask <= '0;
      cur_dst_ei <= '0;
      cur_src_ei <= '0;
      cur_dst_fi <= '0;
      cur_src_fi <= '0;
    end else begin
      en_q <= chan_en;
      block_irq <= 1'b0;
      case (state)
        W_IDLE: if (start_ok) begin
          ptr <= cfg_head_ptr;
          cur_src <= cfg_src_addr;
          cur_dst <= cfg_dst_addr;
          cur_elem <= '0;
          cur_frame <= '0;
          pend_dm <= cfg_mode[1:0];
          pend_sm <= cfg_mode[3:2];
          cnt_q <= '0;
          state <= W_CHECK;
        end
        W_CHECK: begin
          widx <= '0;
          if (!chan_en)                 state <= W_IDLE;
          else if (ptr == CHAIN_END_PTR) state <= W_END;
          else if (ptr[1:0] != 2'b00)   state <= W_ERR;
          else                          state <= W_REQ;
        end
        W_REQ: begin
          if (!chan_en)          state <= W_IDLE;
          else if (rd_req_ready) state <= W_RSP;
        end
        W_RSP: if (rd_rsp_valid) begin
          if (!chan_en)              state <= W_IDLE;
          else if (widx == LAST_IDX) state <= W_LOAD;
          else begin
            widx <= widx + 1'b1;
            state <= W_REQ;
          end
        end
        W_LOAD: begin
          if (!chan_en) state <= W_IDLE;
          else begin
            cur_dst <= nxt_dst;
            cur_src <= nxt_src;
            cur_elem <= w_count[ELEM_W-1:0];
            cur_frame <= w_frame[15:0];
            cur_irq_mask <= w_frame[31:16];
            cur_dst_ei <= w_eidx[15:0];
            cur_src_ei <= w_eidx[31:16];
            cur_dst_fi <= desc_words[SLOT_DFIDX*W +: W];
            cur_src_fi <= desc_words[SLOT_SFIDX*W +: W];
            pend_sm <= w_count[25:24];
            pend_dm <= w_count[27:26];
            ptr <= w_next;
            cnt_q <= cnt_q + 1'b1;
            state <= W_START;
          end
        end
        W_START: state <= W_WAIT;
        W_WAIT: if (xfer_done) begin
          block_irq <= cur_irq_mask[BLOCK_IE_BIT];
          state <= chan_en ? W_CHECK : W_IDLE;
        end
        W_END, W_ERR: if (!chan_en) state <= W_IDLE;
        default: state <= W_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (state == W_REQ) && chan_en;
  assign rd_req_addr  = ptr + {{(W-IDX_W-2){1'b0}}, widx, 2'b00};
  assign rd_rsp_ready = (state == W_RSP);
  assign xfer_start   = (state == W_START);
  assign chain_end    = (state == W_END);
  assign err_align    = (state == W_ERR);
  assign busy         = !(state inside {W_IDLE, W_END, W_ERR});
  assign desc_num     = 16'(cnt_q);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (!chan_en || (rd_req_valid && $stable(rd_req_addr))));
  assert_req_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_addr[1:0] == 2'b00);
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    block_irq |-> cur_irq_mask[BLOCK_IE_BIT]);
  assert_irq_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    block_irq |-> $past(xfer_done));
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(desc_num) |-> (desc_num == $past(desc_num) + 16'd1 || desc_num == 16'd0));
  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_align |-> (!rd_req_valid && !xfer_start && !busy));
endmodule

// File: tb/tb_ll_desc_walker.sv
`timescale 1ns/1ps
module tb_ll_desc_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b0;
  logic [10:0] cfg_mode = '0;
  logic [31:0] cfg_head_ptr = '0, cfg_src_addr = '0, cfg_dst_addr = '0;
  logic rd_req_valid, rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic rd_rsp_valid = 1'b0, rd_rsp_ready;
  logic [31:0] rd_rsp_data = '0;
  logic xfer_start, xfer_done = 1'b0;
  logic [31:0] cur_src, cur_dst, cur_dst_fi, cur_src_fi;
  logic [23:0] cur_elem;
  logic [15:0] cur_frame, cur_irq_mask, cur_dst_ei, cur_src_ei, desc_num;
  logic block_irq, chain_end, err_align, busy;

  always #5 clk = ~clk;

  ll_desc_walker dut (.*);

  int n_checks = 0, n_fail = 0;
  int g_r = 0, g_n = 1, g_nsm = 0, g_ndm = 0;
  bit g_bad_next = 0;
  int req_count = 0, start_count = 0, cnt = 0;
  logic [31:0] req_log [0:63];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dword(input int i, input int k);
    int elem = 3 + i + g_r % 5;
    int frame = 2 + i;
    bit last = (i == g_n - 1);
    logic [15:0] mask = 16'h0008 | ((last || (i == 0 && g_r % 2 == 1)) ? 16'h0020 : 16'h0000);
    case (k)
      0: return last ? (g_bad_next ? 32'h0000_0102 : 32'hFFFF_FFFC) : 32'(32'h40 + 32 * (i + 1));
      1: return 32'(elem) | (32'(g_nsm) << 24) | (32'(g_ndm) << 26) | (32'd2 << 29);
      2: return 32'h2000_0000 + (32'(g_r) << 8) + (32'(i) << 4);
      3: return {mask, 16'(frame)};
      4: return {16'(32'h20 + g_r), 16'(32'h10 + i)};
      5: return 32'(32'h100 + i);
      6: return 32'(32'h200 + g_r);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mem_read(input logic [31:0] a);
    int off = int'(a) - 32'h40;
    if (off < 0 || off >= 32 * 8) return 32'hDEAD_BEEF;
    return dword(off / 32, (off / 4) % 8);
  endfunction

  // memory and transfer-start observer: acts 1 ns after each falling edge
  initial begin
    bit req_fire = 0, rsp_fire = 0, pend = 0;
    logic [31:0] paddr = '0, qaddr = '0;
    forever begin
      @(negedge clk); #1;
      cnt++;
      if (rsp_fire) rd_rsp_valid = 1'b0;
      if (req_fire) begin pend = 1; paddr = qaddr; end
      if (pend && !rd_rsp_valid && (cnt % 5) != 3) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data = mem_read(paddr);
        pend = 0;
      end
      rd_req_ready = (cnt % 3) != 2;
      req_fire = rd_req_valid && rd_req_ready;
      if (req_fire) begin
        qaddr = rd_req_addr;
        if (req_count < 64) req_log[req_count] = rd_req_addr;
        req_count++;
      end
      rsp_fire = rd_rsp_valid && rd_rsp_ready;
      if (xfer_start) start_count++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  function automatic logic [31:0] step_addr(input int m, input logic [31:0] prev, input logic [31:0] da,
                                            input int pe, input int pf);
    if (m == 0) return prev + 32'(pe * pf * 4);
    if (m == 1) return da;
    return prev;
  endfunction

  task automatic run_chain(input int r, input int n, input int dm0, input int sm0,
                           input int nsm, input int ndm, input bit bad);
    logic [31:0] es, ed;
    int pe = 0, pf = 0, dm, sm;
    bit addr_ok = 1;
    g_r = r; g_n = n; g_nsm = nsm; g_ndm = ndm; g_bad_next = bad;
    cfg_mode = 11'((2 << 4) | (1 << 8) | (sm0 << 2) | dm0 | ((r % 2) << 10));
    cfg_head_ptr = 32'h40;
    cfg_src_addr = 32'h3000_0000 + 32'(r);
    cfg_dst_addr = 32'h4000_0000 + 32'(r);
    es = cfg_src_addr; ed = cfg_dst_addr;
    tick(1);
    req_count = 0; start_count = 0;
    @(negedge clk); chan_en = 1'b1; #2;
    for (int i = 0; i < n; i++) begin
      while (!xfer_start) tick(1);
      dm = (i == 0) ? dm0 : ndm;
      sm = (i == 0) ? sm0 : nsm;
      ed = step_addr(dm, ed, dword(i, 2), pe, pf);
      es = step_addr(sm, es, dword(i, 2), pe, pf);
      pe = 3 + i + r % 5; pf = 2 + i;
      chk(cur_dst == ed, "R5 destination address", cur_dst, ed);
      chk(cur_src == es, "R5 source address", cur_src, es);
      chk(cur_elem == 24'(pe), "R4 element count", cur_elem, pe);
      chk(cur_frame == 16'(pf), "R4 frame count", cur_frame, pf);
      chk(cur_irq_mask == dword(i, 3)[31:16], "R4 interrupt mask", cur_irq_mask, dword(i, 3)[31:16]);
      chk({cur_src_ei, cur_dst_ei} == dword(i, 4), "R4 element indices", {cur_src_ei, cur_dst_ei}, dword(i, 4));
      chk(cur_dst_fi == dword(i, 5) && cur_src_fi == dword(i, 6), "R4 frame indices",
          {cur_dst_fi, cur_src_fi}, {dword(i, 5), dword(i, 6)});
      chk(desc_num == 16'(i + 1), "R9 descriptor number", desc_num, i + 1);
      chk(block_irq == 1'b0, "R7 no interrupt before done", block_irq, 0);
      tick(1 + (i + r) % 3);
      chk(!rd_req_valid && busy, "R6 waits for done", {rd_req_valid, busy}, 1);
      xfer_done = 1'b1;
      tick(1);
      xfer_done = 1'b0;
      chk(block_irq == dword(i, 3)[21], "R7 block interrupt", block_irq, dword(i, 3)[21]);
      tick(1);
      chk(block_irq == 1'b0, "R7 interrupt is one cycle", block_irq, 0);
    end
    tick(3);
    if (bad) chk(err_align && !chain_end, "R10 misaligned next pointer", {err_align, chain_end}, 2);
    else     chk(chain_end && !err_align, "R8 chain end", {chain_end, err_align}, 2);
    chk(!busy, "R8 idle after chain", busy, 0);
    chk(start_count == n, "R6 one start per descriptor", start_count, n);
    chk(req_count == 7 * n, "R3 word request count", req_count, 7 * n);
    for (int j = 0; j < req_count && j < 64; j++)
      if (req_log[j] != 32'(32'h40 + 32 * (j / 7) + 4 * (j % 7))) addr_ok = 0;
    chk(addr_ok, "R3 word request addresses", addr_ok, 1);
    @(negedge clk); chan_en = 1'b0;
    tick(2);
  endtask

  task automatic run_nostart(input logic [10:0] mode, input string tag);
    cfg_mode = mode; cfg_head_ptr = 32'h40;
    req_count = 0;
    @(negedge clk); chan_en = 1'b1;
    tick(10);
    chk(req_count == 0 && !busy, tag, {req_count, busy}, 0);
    @(negedge clk); chan_en = 1'b0;
    tick(2);
  endtask

  task automatic run_headptr(input logic [31:0] hp, input bit expect_end, input string tag);
    cfg_mode = 11'h120; cfg_head_ptr = hp;
    req_count = 0; start_count = 0;
    @(negedge clk); chan_en = 1'b1;
    tick(5);
    chk(chain_end == expect_end && err_align == !expect_end && !busy, tag,
        {chain_end, err_align, busy}, {expect_end, !expect_end, 1'b0});
    chk(req_count == 0 && start_count == 0 && desc_num == 0, tag, {req_count, start_count}, 0);
    @(negedge clk); chan_en = 1'b0;
    tick(2);
    chk(!chain_end && !err_align, "R8 status clears when disabled", {chain_end, err_align}, 0);
  endtask

  task automatic run_abort(input int k);
    g_r = k; g_n = 2; g_nsm = 2; g_ndm = 1; g_bad_next = 0;
    cfg_mode = 11'h125; cfg_head_ptr = 32'h40;
    req_count = 0; start_count = 0;
    @(negedge clk); chan_en = 1'b1; #2;
    while (req_count < k) tick(1);
    @(negedge clk); chan_en = 1'b0;
    tick(6);
    chk(!busy && !rd_req_valid, "R11 idle after abort", {busy, rd_req_valid}, 0);
    chk(start_count == 0, "R11 no block started", start_count, 0);
    chk(req_count <= k + 1, "R11 no request after abort", req_count, k + 1);
  endtask

  initial begin
    #(150000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(!busy && !rd_req_valid && !rd_rsp_ready && !xfer_start, "R1 reset outputs",
        {busy, rd_req_valid, rd_rsp_ready, xfer_start}, 0);
    chk(!block_irq && !chain_end && !err_align && desc_num == 0, "R1 reset status",
        {block_irq, chain_end, err_align, desc_num}, 0);
    @(negedge clk); rst_n = 1'b1;
    tick(2);
    chk(!busy && desc_num == 0, "R1 idle after reset", {busy, desc_num}, 0);
    run_nostart(11'h020, "R2 list mode bit clear");
    run_nostart(11'h110, "R2 descriptor type 1");
    run_nostart(11'h130, "R2 descriptor type 3");
    run_headptr(32'hFFFF_FFFC, 1'b1, "R8 sentinel head pointer");
    run_headptr(32'h0000_0042, 1'b0, "R10 misaligned head pointer");
    run_headptr(32'h0000_0041, 1'b0, "R10 misaligned head pointer odd");
    for (int r = 0; r < 243; r++)
      run_chain(r, 1 + r % 3, (r / 3) % 3, (r / 9) % 3, (r / 27) % 3, (r / 81) % 3, 1'b0);
    run_chain(7, 1, 1, 2, 2, 1, 1'b1);
    run_chain(8, 2, 2, 1, 1, 2, 1'b1);
    for (int k = 1; k <= 7; k++) run_abort(k);
    run_chain(5, 2, 0, 0, 0, 0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule